// File: doc/BRIEF.md
# Dual-Port Interleaving Converter Input Front End

This block sits between two parallel 14-bit data ports and the output latch of a current-steering converter. It has two operating modes and selects between them with a two-bit mode select. In single-port mode the applied clock is the data-rate clock, and the block acts as a two-stage buffer on one chosen port. In interleaved mode the applied clock runs at twice the data rate. An internal divide-by-two produces the word clock that captures both ports together. The output latch then presents the first port's word and the second port's word on consecutive fast cycles.

The divided word clock is driven out on `word_clk` so that upstream logic can time its data changes to it. A reset pulse puts the divider into a known phase: `word_clk` goes high during reset, falls on the first edge after release and rises again on the second edge. Both ports are captured on that second edge. The block drives the output code and its complement, where the complement is full scale minus the code.

Top module: `dac_pair_front`

## Requirements
- R1: Each output code is a 14-bit unsigned value. On every cycle out of reset, `code_n` equals 16383 minus `code`.
- R2: While `rst` is sampled high on a clock edge, the next outputs are `word_clk` = 1, `code` = 0 and `code_n` = 16383.
- R3: With `mode_sel` = 00, `word_clk` goes to 0 on the first edge at which `rst` is sampled low. It goes to 1 on the second such edge, and on that edge `port_a` is captured into latch A and `port_b` into latch B.
- R4: With `mode_sel` = 00 and `rst` low, `word_clk` inverts on every edge of `clk`.
- R5: With `mode_sel` = 00, after the capture edge (the edge on which `word_clk` rises) the next edge loads latch A into `code` and the edge after that loads latch B into `code`.
- R6: With `mode_sel` = 01, every edge loads `port_a` into latch A and loads the previous contents of latch A into `code`, so a word reaches `code` two edges after it is applied.
- R7: With `mode_sel` = 10, the same two-stage path runs from `port_b` through latch B. `port_a` has no effect and latch A keeps its contents.
- R8: `mode_sel` = 11 is reserved and behaves exactly as 01.
- R9: In either single-port mode (`mode_sel` other than 00), `word_clk` is held at 1.
- R10: Reset is synchronous: `rst` takes effect on the clock edge that samples it, in any mode, including partway through an interleaved pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Applied clock: the data-rate clock in single-port mode, twice the data rate in interleaved mode |
| rst | input | 1 | Synchronous active-high reset; also aligns the divider phase |
| mode_sel | input | 2 | 00 interleaved, 01 port A only, 10 port B only, 11 same as 01 |
| port_a | input | 14 | First data port, unsigned code |
| port_b | input | 14 | Second data port, unsigned code |
| word_clk | output | 1 | Divided word clock, exported for data alignment |
| code | output | 14 | Output latch code |
| code_n | output | 14 | Complementary code, 16383 minus `code` |

## Verification
The assertions assume that `mode_sel` is sampled only on edges of `clk` and holds a valid two-bit value. They also assume that `rst` is high from time zero until at least one edge has seen it, so every property can be disabled during reset. The latency property for the port-A path additionally assumes that the mode has stayed at 01 for two consecutive edges. To keep within these assumptions, the stimulus changes `mode_sel`, `rst` and the ports only at falling edges. It holds each mode for runs of several cycles, with occasional reset pulses in between, and opens with a reset pulse that spans two edges.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

   // Mode select encoding; the reserved value aliases port-A single mode.
   typedef enum logic [1:0] {
      DPF_PAIR   = 2'b00,
      DPF_SOLO_A = 2'b01,
      DPF_SOLO_B = 2'b10,
      DPF_ALIAS  = 2'b11
   } dpf_mode_e;

   typedef struct packed {
      logic pair;     // interleaved, divider running
      logic solo_b;   // single-port on port B
   } dpf_route_t;

   function automatic dpf_route_t dpf_decode(input logic [1:0] sel);
      dpf_route_t r;
      r.pair   = (sel == DPF_PAIR);
      r.solo_b = (sel == DPF_SOLO_B);
      return r;
   endfunction

   function automatic int unsigned dpf_full_scale(input int unsigned w);
      return (32'd1 << w) - 32'd1;
   endfunction

endpackage

// File: rtl/dpf_phase_div.sv
module dpf_phase_div #(
   parameter bit PHASE_AT_RESET = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic phase_q,
   output logic capture
);

   // Phase register: forced to its reset level, toggled while running,
   // parked at the reset level while the divider is stopped.
   always_ff @(posedge clk) begin
      if (rst)
         phase_q <= PHASE_AT_RESET;
      else if (run)
         phase_q <= ~phase_q;
      else
         phase_q <= PHASE_AT_RESET;
   end

   // The capture edge is the one on which the phase rises.
   generate
      if (PHASE_AT_RESET) begin : g_rise_low_start
         assign capture = run & ~rst & ~phase_q;
      end else begin : g_rise_high_start
         assign capture = run & ~rst & phase_q;
      end
   endgenerate

endmodule

// File: rtl/dpf_in_latch.sv
module dpf_in_latch #(
   parameter int unsigned WIDTH = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= din;
   end

endmodule

// File: rtl/dpf_out_stage.sv
module dpf_out_stage #(
   parameter int unsigned WIDTH    = 14,
   parameter bit          COMP_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pick_b,
   input  logic [WIDTH-1:0] word_a,
   input  logic [WIDTH-1:0] word_b,
   output logic [WIDTH-1:0] code,
   output logic [WIDTH-1:0] code_n
);

   localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

   logic [WIDTH-1:0] next_code;

   assign next_code = pick_b ? word_b : word_a;

   always_ff @(posedge clk) begin
      if (rst)
         code <= '0;
      else
         code <= next_code;
   end

   generate
      if (COMP_REG) begin : g_comp_reg
         // Complement held in its own register, no subtractor after the latch.
         always_ff @(posedge clk) begin
            if (rst)
               code_n <= FULL;
            else
               code_n <= FULL - next_code;
         end
      end else begin : g_comp_comb
         assign code_n = FULL - code;
      end
   endgenerate

endmodule

// File: rtl/dac_pair_front.sv
module dac_pair_front #(
   parameter int unsigned CODE_W   = 14,
   parameter bit          COMP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_sel,
   input  logic [CODE_W-1:0] port_a,
   input  logic [CODE_W-1:0] port_b,
   output logic              word_clk,
   output logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] code_n
);
   import dpf_pkg::*;

   localparam int unsigned N_PORTS = 2;

   generate
      if (CODE_W < 2 || CODE_W > 24) begin : g_bad_width
         $error("dac_pair_front: CODE_W out of supported range 2..24");
      end
   endgenerate

   dpf_route_t route;
   logic       phase_q;
   logic       capture;
   logic       pick_b;

   logic [N_PORTS-1:0]             load;
   logic [N_PORTS-1:0][CODE_W-1:0] port_bus;
   logic [N_PORTS-1:0][CODE_W-1:0] latch_q;

   assign route       = dpf_decode(mode_sel);
   assign port_bus[0] = port_a;
   assign port_bus[1] = port_b;

   dpf_phase_div #(
      .PHASE_AT_RESET (1'b1)
   ) u_div (
      .clk     (clk),
      .rst     (rst),
      .run     (route.pair),
      .phase_q (phase_q),
      .capture (capture)
   );

   // Load enables: both ports together on the capture edge when interleaved,
   // only the selected port on every edge otherwise.
   assign load[0] = route.pair ? capture : ~route.solo_b;
   assign load[1] = route.pair ? capture :  route.solo_b;

   generate
      for (genvar p = 0; p < N_PORTS; p++) begin : g_port
         dpf_in_latch #(
            .WIDTH (CODE_W)
         ) u_lat (
            .clk  (clk),
            .rst  (rst),
            .load (load[p]),
            .din  (port_bus[p]),
            .q    (latch_q[p])
         );
      end
   endgenerate

   // Interleaved: word A while the phase is high (first half after capture),
   // word B while low. Single-port: the selected latch.
   assign pick_b = route.pair ? ~phase_q : route.solo_b;

   dpf_out_stage #(
      .WIDTH    (CODE_W),
      .COMP_REG (COMP_REG)
   ) u_out (
      .clk    (clk),
      .rst    (rst),
      .pick_b (pick_b),
      .word_a (latch_q[0]),
      .word_b (latch_q[1]),
      .code   (code),
      .code_n (code_n)
   );

   assign word_clk = phase_q;

endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
   parameter int unsigned CODE_W = 14
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        mode_sel,
   input logic [CODE_W-1:0] port_a,
   input logic [CODE_W-1:0] port_b,
   input logic              word_clk,
   input logic [CODE_W-1:0] code,
   input logic [CODE_W-1:0] code_n
);

   localparam logic [CODE_W:0] FULL = {1'b0, {CODE_W{1'b1}}};

   logic pair_mode;
   logic solo_a_mode;
   assign pair_mode   = (mode_sel == 2'b00);
   assign solo_a_mode = (mode_sel == 2'b01) || (mode_sel == 2'b11);

   assert_complement_R1: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, code} + {1'b0, code_n}) == FULL);

   assert_reset_state_R2: assert property (@(posedge clk)
      rst |=> (word_clk && code == '0));

   assert_first_fall_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && pair_mode) |=> !word_clk);

   assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
      pair_mode |=> (word_clk != $past(word_clk)));

   assert_solo_latency_R6: assert property (@(posedge clk) disable iff (rst)
      (solo_a_mode ##1 solo_a_mode) |=> (code == $past(port_a, 2)));

   assert_hold_high_R9: assert property (@(posedge clk) disable iff (rst)
      !pair_mode |=> word_clk);

endmodule

bind dac_pair_front dpf_checker #(.CODE_W(CODE_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mode_sel (mode_sel),
   .port_a   (port_a),
   .port_b   (port_b),
   .word_clk (word_clk),
   .code     (code),
   .code_n   (code_n)
);

// File: tb/sim_dac_pair_front.sv
`timescale 1ns/1ps
module sim_dac_pair_front;

   localparam int W    = 14;
   localparam int FULL = 16383;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [1:0]   mode_sel = 2'b00;
   logic [W-1:0] port_a = '0;
   logic [W-1:0] port_b = '0;
   logic         word_clk;
   logic [W-1:0] code;
   logic [W-1:0] code_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   // Expected state, derived from the requirements.
   logic         m_ph = 1'b1;
   logic [W-1:0] m_la = '0;
   logic [W-1:0] m_lb = '0;
   logic [W-1:0] m_code = '0;

   always #2 clk = ~clk;

   dac_pair_front u0 (
      .clk      (clk),
      .rst      (rst),
      .mode_sel (mode_sel),
      .port_a   (port_a),
      .port_b   (port_b),
      .word_clk (word_clk),
      .code     (code),
      .code_n   (code_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Advance the expected state across one edge.
   task automatic model_edge(input logic r, input logic [1:0] m,
                             input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] nc;
      if (r) begin
         m_ph = 1'b1; m_la = '0; m_lb = '0; m_code = '0;
      end else if (m == 2'b00) begin
         nc = m_ph ? m_la : m_lb;      // R5 ordering
         if (!m_ph) begin m_la = a; m_lb = b; end   // R3 joint capture
         m_ph = ~m_ph;
         m_code = nc;
      end else if (m == 2'b10) begin
         m_code = m_lb; m_lb = b; m_ph = 1'b1;
      end else begin
         m_code = m_la; m_la = a; m_ph = 1'b1;
      end
   endtask

   task automatic step(input logic r, input logic [1:0] m,
                       input logic [W-1:0] a, input logic [W-1:0] b);
      string tc;
      rst = r; mode_sel = m; port_a = a; port_b = b;
      model_edge(r, m, a, b);
      @(posedge clk);
      @(negedge clk);
      tc = r ? "R2" : (m == 2'b00 ? "R5" : (m == 2'b10 ? "R7" : (m == 2'b11 ? "R8" : "R6")));
      check(r ? "R2 word_clk" : (m == 2'b00 ? "R4 word_clk" : "R9 word_clk"),
            int'(word_clk), int'(m_ph));
      check({tc, " code"}, int'(code), int'(m_code));
      check("R1 code_n", int'(code_n), FULL - int'(m_code));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [1:0] rm;
      void'($urandom(32'd20240611));
      rm = 2'b00;

      // Reset state R2
      step(1'b1, 2'b00, 14'h0AAA, 14'h1555);
      step(1'b1, 2'b00, 14'h0AAA, 14'h1555);
      check("R2 reset code_n", int'(code_n), 16383);

      // Reset release alignment R3 and ordering R5
      step(1'b0, 2'b00, 14'h1111, 14'h2222);
      check("R3 first edge low", int'(word_clk), 0);
      step(1'b0, 2'b00, 14'h1111, 14'h2222);
      check("R3 second edge high", int'(word_clk), 1);
      step(1'b0, 2'b00, 14'h3333, 14'h0444);
      check("R5 port A word first", int'(code), 14'h1111);
      step(1'b0, 2'b00, 14'h3333, 14'h0444);
      check("R5 port B word second", int'(code), 14'h2222);
      step(1'b0, 2'b00, 14'h0001, 14'h0002);
      check("R5 next pair A", int'(code), 14'h3333);

      // Synchronous reset mid-pair R10
      step(1'b1, 2'b00, 14'h0001, 14'h0002);
      check("R10 reset mid pair code", int'(code), 0);
      check("R10 reset mid pair word_clk", int'(word_clk), 1);

      // Port B single mode; port A ignored R7
      step(1'b0, 2'b10, 14'h0005, 14'h0007);
      step(1'b0, 2'b10, 14'h3FFF, 14'h0008);
      check("R7 port B latency", int'(code), 7);
      check("R1 code_n at 7", int'(code_n), 16376);
      step(1'b0, 2'b01, 14'h0009, 14'h0000);
      check("R7 latch A untouched by port_a", int'(code), 0);

      // Reserved code behaves as port A mode R8; extremes for R1
      step(1'b0, 2'b11, 14'h3FFF, 14'h0000);
      step(1'b0, 2'b11, 14'h0000, 14'h0000);
      check("R8 alias latency", int'(code), 16383);
      check("R1 code_n at full scale", int'(code_n), 0);
      check("R9 word_clk held", int'(word_clk), 1);

      // Constrained random runs of modes with occasional reset pulses
      for (int i = 0; i < 4000; i++) begin
         logic r;
         if (($urandom % 24) == 0) rm = 2'($urandom % 4);
         r = (($urandom % 150) == 0);
         step(r, rm, W'($urandom % (FULL + 1)), W'($urandom % (FULL + 1)));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule